// File: doc/BRIEF.md
# Eight-Channel Converter Serial Command Front End

This block is the digital side of an eight-channel voltage-output converter. A host drives a three-wire serial link: a shift clock, a data line and a frame-select strobe. There is also an active-low clear line. All four lines are sampled by a faster system clock through two-flop synchronisers, and edges are found by comparing successive samples. While the strobe is low, each rising shift-clock edge moves one data bit into a 16-bit shift register. When the strobe returns high, the block acts on the word it holds.

Each word carries a 4-bit command field first, then the channel code MSB first, then padding up to 16 bits. The default code width is 10 bits, which leaves 2 padding bits. With an 8-bit code there are 4. The command field can:
- write one channel register;
- write the same code to all eight channel registers;
- put the part to sleep;
- do nothing apart from waking the part.

The channel registers keep their values through sleep. The most significant bit of the shift register drives a serial output, so several devices can share one link as a single long shift register. The eight held codes and the sleep flag are the outputs that go to the analog section.

Top module: `dac_serial_frontend`

## Requirements
- R1: After power-up reset, every channel code is zero, the sleep flag is 0 and the serial output is 0.
- R2: The shift register takes one data bit on each rising shift-clock edge seen while the frame strobe is low. Shift-clock edges seen while the strobe is high change neither the shift register nor the serial output.
- R3: In the shift register, bits 15..12 are the command field, where bit 15 is the first bit shifted in. The next CODE_W bits, from bit 11 down, are the code with its MSB first. Any remaining low bits are ignored padding.
- R4: A rising strobe edge with command value 1 to 8 writes the code into channel (value - 1) only and clears the sleep flag.
- R5: A rising strobe edge with command value 15 writes the code into all eight channels and clears the sleep flag.
- R6: A rising strobe edge with command value 14 sets the sleep flag, ignores the code and leaves every channel register unchanged.
- R7: A rising strobe edge with command value 0 or 9 to 13 leaves every channel register unchanged and clears the sleep flag.
- R8: The serial output is shift-register bit 15, so it presents each data bit 16 rising shift-clock edges after that bit entered.
- R9: A falling edge on the clear line zeroes the shift register and all channel registers and leaves the sleep flag unchanged. If a clear and a strobe edge are seen in the same cycle, the clear wins.
- R10: A rising strobe edge after fewer than 16 shift-clock edges decodes whatever the shift register holds at that moment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that samples the serial lines |
| rst_n | input | 1 | Asynchronous active-low power-up reset |
| sck_i | input | 1 | Serial shift clock, idle low |
| din_i | input | 1 | Serial data in |
| csld_i | input | 1 | Frame strobe: low enables shifting, a rising edge acts on the word |
| clr_n_i | input | 1 | Clear line, acts on its falling edge |
| dout_o | output | 1 | Serial pass-through output for chaining |
| codes_o | output | NUM_CH*CODE_W | Held channel codes, channel i at bits [i*CODE_W +: CODE_W] |
| sleep_o | output | 1 | Sleep indication |

## Verification
Some properties are checked on every cycle:
- the shift register holds still and the serial output does not move when no shift event occurs;
- one shift moves the previous bit 14 to the output;
- a clear leaves every code at zero;
- a sleep command sets the flag and freezes the codes;
- a no-change or channel command clears the flag;
- a broadcast leaves all channels equal.

Other behaviour needs the bench's frames and the per-clock reference model:
- that the field positions and bit order are right;
- that a chained 32-bit transfer delays the data by exactly 16 edges;
- that a short frame decodes a partly shifted word;
- that waking from sleep keeps the channels the waking word does not address.

// File: rtl/dac_fe_pkg.sv
package dac_fe_pkg;

    localparam int unsigned ADDR_W = 4;

    localparam logic [ADDR_W-1:0] ADDR_SLEEP = 4'hE;
    localparam logic [ADDR_W-1:0] ADDR_BCAST = 4'hF;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_ONE,
        CMD_ALL,
        CMD_SLEEP
    } cmd_e;

    // Map a command field onto its action for a bank of nch channels.
    function automatic cmd_e classify(input logic [ADDR_W-1:0] a, input int unsigned nch);
        if (a == ADDR_SLEEP) return CMD_SLEEP;
        if (a == ADDR_BCAST) return CMD_ALL;
        if (a != '0 && 32'(a) <= nch) return CMD_ONE;
        return CMD_NOP;
    endfunction

endpackage

// File: rtl/dac_fe_sync.sv
module dac_fe_sync #(
    parameter int unsigned W      = 4,
    parameter int unsigned EDGE_W = 3,
    parameter logic [W-1:0] IDLE  = '0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [W-1:0]      raw_i,
    output logic [W-1:0]      lvl_o,
    output logic [EDGE_W-1:0] prv_o
);

    typedef struct packed {
        logic [W-1:0]      s1;
        logic [W-1:0]      s2;
        logic [EDGE_W-1:0] prv;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.s1  = raw_i;
        st_d.s2  = st_q.s1;
        st_d.prv = st_q.s2[EDGE_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.s1  <= IDLE;
            st_q.s2  <= IDLE;
            st_q.prv <= IDLE[EDGE_W-1:0];
        end else begin
            st_q <= st_d;
        end
    end

    assign lvl_o = st_q.s2;
    assign prv_o = st_q.prv;

endmodule

// File: rtl/dac_fe_shift.sv
module dac_fe_shift #(
    parameter int unsigned WORD_W = 16,
    parameter int unsigned HEAD_W = 14
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_i,
    input  logic              clr_i,
    input  logic              din_i,
    output logic [HEAD_W-1:0] head_o,
    output logic              dout_o
);

    typedef struct packed {
        logic [WORD_W-1:0] sr;
    } shreg_t;

    shreg_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.sr = '0;
        end else if (shift_i) begin
            st_d.sr = {st_q.sr[WORD_W-2:0], din_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign head_o = st_q.sr[WORD_W-1 -: HEAD_W];
    assign dout_o = st_q.sr[WORD_W-1];

    // R2
    hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!shift_i && !clr_i) |=> ($stable(st_q.sr) && $stable(dout_o)));

    // R8
    dout_advance_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (shift_i && !clr_i) |=> (dout_o == $past(st_q.sr[WORD_W-2])));

    // R9
    shift_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (st_q.sr == '0));

endmodule

// File: rtl/dac_fe_regs.sv
module dac_fe_regs
    import dac_fe_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned CODE_W = 10,
    localparam int unsigned HEAD_W = ADDR_W + CODE_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     load_i,
    input  logic                     clr_i,
    input  logic [HEAD_W-1:0]        head_i,
    output logic [NUM_CH*CODE_W-1:0] codes_o,
    output logic                     sleep_o
);

    typedef struct packed {
        logic [NUM_CH-1:0][CODE_W-1:0] code;
        logic                          sleep;
    } bank_t;

    bank_t st_d, st_q;

    logic [ADDR_W-1:0] addr;
    logic [CODE_W-1:0] value;
    cmd_e              cmd;
    logic [NUM_CH-1:0] sel;

    assign addr  = head_i[HEAD_W-1 -: ADDR_W];
    assign value = head_i[CODE_W-1:0];
    assign cmd   = classify(addr, NUM_CH);

    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_chan
        assign sel[ch] = (cmd == CMD_ALL) ||
                         ((cmd == CMD_ONE) && (addr == ADDR_W'(ch + 1)));
        assign codes_o[ch*CODE_W +: CODE_W] = st_q.code[ch];
    end

    always_comb begin
        st_d = st_q;
        if (clr_i) begin
            st_d.code = '0;
        end else if (load_i) begin
            st_d.sleep = (cmd == CMD_SLEEP);
            for (int ch = 0; ch < NUM_CH; ch++) begin
                if (sel[ch]) st_d.code[ch] = value;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign sleep_o = st_q.sleep;

    // R6
    sleep_freeze_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clr_i && cmd == CMD_SLEEP) |=> (sleep_o && $stable(codes_o)));

    // R7
    nop_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clr_i && cmd == CMD_NOP) |=> (!sleep_o && $stable(codes_o)));

    // R4
    chan_wake_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clr_i && cmd == CMD_ONE) |=> !sleep_o);

    // R5
    bcast_equal_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (load_i && !clr_i && cmd == CMD_ALL) |=>
        (!sleep_o && codes_o[CODE_W-1:0] == codes_o[NUM_CH*CODE_W-1 -: CODE_W]));

    // R9
    bank_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_i |=> (codes_o == '0 && $stable(sleep_o)));

endmodule

// File: rtl/dac_serial_frontend.sv
module dac_serial_frontend
    import dac_fe_pkg::*;
#(
    parameter int unsigned NUM_CH = 8,
    parameter int unsigned CODE_W = 10,
    parameter int unsigned WORD_W = 16
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     sck_i,
    input  logic                     din_i,
    input  logic                     csld_i,
    input  logic                     clr_n_i,
    output logic                     dout_o,
    output logic [NUM_CH*CODE_W-1:0] codes_o,
    output logic                     sleep_o
);

    localparam int unsigned HEAD_W = ADDR_W + CODE_W;
    localparam int unsigned IN_W   = 4;
    localparam int unsigned EDGE_W = 3;
    // Line order: {din, clr_n, strobe, sck}; idle levels 0,1,1,0.
    localparam logic [IN_W-1:0] IN_IDLE = 4'b0110;

    logic [IN_W-1:0]   lvl;
    logic [EDGE_W-1:0] prv;
    logic              sck_rise, cs_rise, clr_fall, shift_evt;
    logic [HEAD_W-1:0] head;

    dac_fe_sync #(
        .W      (IN_W),
        .EDGE_W (EDGE_W),
        .IDLE   (IN_IDLE)
    ) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .raw_i ({din_i, clr_n_i, csld_i, sck_i}),
        .lvl_o (lvl),
        .prv_o (prv)
    );

    assign sck_rise  =  lvl[0] & ~prv[0];
    assign cs_rise   =  lvl[1] & ~prv[1];
    assign clr_fall  = ~lvl[2] &  prv[2];
    assign shift_evt =  sck_rise & ~lvl[1];

    dac_fe_shift #(
        .WORD_W (WORD_W),
        .HEAD_W (HEAD_W)
    ) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .shift_i (shift_evt),
        .clr_i   (clr_fall),
        .din_i   (lvl[3]),
        .head_o  (head),
        .dout_o  (dout_o)
    );

    dac_fe_regs #(
        .NUM_CH (NUM_CH),
        .CODE_W (CODE_W)
    ) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (cs_rise),
        .clr_i   (clr_fall),
        .head_i  (head),
        .codes_o (codes_o),
        .sleep_o (sleep_o)
    );

endmodule

// File: tb/tb_dac_serial_frontend.sv
module tb_dac_serial_frontend;

    localparam int NCH = 8;
    localparam int CW  = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic sck = 1'b0, din = 1'b0, cs = 1'b1, clr_n = 1'b1;
    logic dout, sleep;
    logic [NCH*CW-1:0] codes;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #4 clk = ~clk;

    dac_serial_frontend dut (
        .clk(clk), .rst_n(rst_n), .sck_i(sck), .din_i(din), .csld_i(cs),
        .clr_n_i(clr_n), .dout_o(dout), .codes_o(codes), .sleep_o(sleep)
    );

    task automatic chk(string tag, longint act, longint exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic int dcode(int ch);
        return int'(codes[ch*CW +: CW]);
    endfunction

    // Behavioural reference: history of raw lines, 3-cycle reaction.
    logic [3:0] hist [5];
    logic [15:0] m_sr;
    int m_code [NCH];
    bit m_sleep;

    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 5; i++) hist[i] = 4'b0110;
            m_sr = '0; m_sleep = 0;
            for (int i = 0; i < NCH; i++) m_code[i] = 0;
        end else begin
            for (int i = 4; i > 0; i--) hist[i] = hist[i-1];
            hist[0] = {din, clr_n, cs, sck};
            if (hist[4][2] && !hist[3][2]) begin
                m_sr = '0;
                for (int i = 0; i < NCH; i++) m_code[i] = 0;
            end else begin
                if (hist[3][0] && !hist[4][0] && !hist[3][1])
                    m_sr = {m_sr[14:0], hist[3][3]};
                if (hist[3][1] && !hist[4][1]) begin
                    int a;
                    int v;
                    a = int'(m_sr[15:12]);
                    v = int'(m_sr[11:2]);
                    if (a == 14) m_sleep = 1;
                    else begin
                        m_sleep = 0;
                        if (a == 15) for (int i = 0; i < NCH; i++) m_code[i] = v;
                        else if (a >= 1 && a <= NCH) m_code[a-1] = v;
                    end
                end
            end
            for (int i = 0; i < NCH; i++) chk("R4 model code", dcode(i), m_code[i]);
            chk("R6 model sleep", sleep, m_sleep);
            chk("R8 model dout", dout, m_sr[15]);
        end
    end

    task automatic tick(int n);
        repeat (n) @(posedge clk);
        #2;
    endtask

    task automatic put_bit(logic b);
        din = b; tick(2);
        sck = 1'b1; tick(3);
        sck = 1'b0; tick(3);
    endtask

    task automatic frame(logic [15:0] w);
        cs = 1'b0; tick(3);
        for (int i = 15; i >= 0; i--) put_bit(w[i]);
        cs = 1'b1; tick(6);
    endtask

    function automatic logic [15:0] mk(logic [3:0] a, logic [9:0] c);
        return {a, c, 2'b00};
    endfunction

    initial begin
        logic [15:0] wa, wb;
        logic dsave;
        tick(4);
        rst_n = 1'b1;
        tick(3);
        // R1
        chk("R1 codes", codes, 0);
        chk("R1 sleep", sleep, 0);
        chk("R1 dout", dout, 0);

        frame(mk(4'd3, 10'h2A5));
        chk("R4 ch2 written", dcode(2), 10'h2A5);
        chk("R4 ch0 untouched", dcode(0), 0);
        chk("R3 ch3 untouched", dcode(3), 0);

        frame(mk(4'd15, 10'h155));
        for (int i = 0; i < NCH; i++) chk("R5 broadcast", dcode(i), 10'h155);

        frame(mk(4'd1, 10'h3FF));
        frame(mk(4'd14, 10'h000));
        chk("R6 sleep set", sleep, 1);
        chk("R6 ch0 kept", dcode(0), 10'h3FF);
        chk("R6 ch1 kept", dcode(1), 10'h155);

        frame(mk(4'd0, 10'h123));
        chk("R7 wake by 0", sleep, 0);
        chk("R7 ch2 kept", dcode(2), 10'h155);
        chk("R7 ch0 kept", dcode(0), 10'h3FF);

        frame(mk(4'd14, 10'h3AA));
        chk("R6 sleep again", sleep, 1);
        frame(mk(4'd11, 10'h0F0));
        chk("R7 wake by 11", sleep, 0);
        chk("R7 ch3 kept", dcode(3), 10'h155);

        frame(mk(4'd14, 10'h001));
        frame(mk(4'd8, 10'h0AA));
        chk("R4 wake by load", sleep, 0);
        chk("R4 ch7 written", dcode(7), 10'h0AA);
        chk("R4 ch6 kept", dcode(6), 10'h155);

        // R2: shift clock with strobe high is ignored
        dsave = dout;
        for (int i = 0; i < 5; i++) put_bit(~dsave);
        tick(4);
        chk("R2 dout held", dout, dsave);
        chk("R2 ch7 held", dcode(7), 10'h0AA);

        // R8: 32-bit chained transfer
        wa = mk(4'd5, 10'h2C3);
        wb = mk(4'd6, 10'h1E7);
        cs = 1'b0; tick(3);
        for (int i = 15; i >= 0; i--) put_bit(wa[i]);
        tick(2);
        chk("R8 dout after 16", dout, wa[15]);
        for (int i = 15; i >= 1; i--) begin
            put_bit(wb[i]);
            tick(1);
            chk("R8 delayed bit", dout, wa[i-1]);
        end
        put_bit(wb[0]);
        cs = 1'b1; tick(6);
        chk("R3 second word decoded", dcode(5), 10'h1E7);
        chk("R3 first word passed", dcode(4), 10'h155);

        // R10: short frame, register now 0x79CA -> ch6 gets 0x272
        cs = 1'b0; tick(3);
        put_bit(1'b1); put_bit(1'b0); put_bit(1'b1); put_bit(1'b0);
        cs = 1'b1; tick(6);
        chk("R10 short frame", dcode(6), 10'h272);

        // R9: clear while asleep
        frame(mk(4'd14, 10'h000));
        clr_n = 1'b0; tick(6);
        clr_n = 1'b1; tick(6);
        chk("R9 codes zero", codes, 0);
        chk("R9 sleep kept", sleep, 1);
        chk("R9 dout zero", dout, 0);

        frame(mk(4'd2, 10'h3C3));
        cs = 1'b0; tick(3);
        for (int i = 0; i < 8; i++) put_bit(1'b1);
        clr_n = 1'b0; tick(6);
        clr_n = 1'b1; tick(6);
        chk("R9 shift cleared", dout, 0);
        cs = 1'b1; tick(6);
        chk("R9 clear then nop", codes, 0);
        chk("R9 nop wakes", sleep, 0);

        tick(10);
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule